// File: doc/BRIEF.md
# Modified/Invalid Coherence Directory

This block is the home agent for a group of private caches that use a two-state coherence scheme: a line is either held modified by exactly one core or by nobody. For every tracked line the directory keeps an ownership record, a valid bit and a core number. It arbitrates exclusive-access requests and writebacks from the cores, and read and write accesses from a DMA agent. It sends forwarded requests and invalidations to the current owners, responses to the cores, and read or byte-masked write commands to a backing memory.

A request for a line with no owner is served from memory. The requester becomes the owner when the data comes back. A request for an owned line is forwarded to the owner so that the data moves from cache to cache, and the requester is recorded as owner in the same cycle. A writeback is accepted only from the recorded owner. From any other core it is refused. Before a DMA access touches an owned line, the owner is invalidated and must return its copy. That copy is merged into or returned by the DMA access and is written to memory. Only one memory or invalidation exchange is in flight at a time. No exchange ever times out.

Top module: `mi_dir_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, all output valids are 0 and no line has an owner, so the first exclusive request to any line goes to memory.
- R2: An exclusive request (`req_kind`=0) to an unowned line issues a memory read (`mem_req_write`=0) one cycle after acceptance. One cycle after `mem_rsp_valid`, a response with `rsp_kind`=0 (data) carries `mem_rsp_data` to the requester, and the requester becomes the owner.
- R3: An exclusive request to an owned line produces, one cycle later, `fwd_kind`=0 to the old owner, with `fwd_req_core` naming the requester. The requester is owner from then on, there is no memory access, and the directory stays ready.
- R4: A writeback (`req_kind`=1) from the recorded owner issues a memory write of `req_data` with all byte enables set and clears the ownership. One cycle after `mem_rsp_valid`, `rsp_kind`=1 (ack) goes to that core.
- R5: A writeback from any core that is not the recorded owner gets `rsp_kind`=2 (refusal) one cycle later. It issues no memory request and leaves the ownership unchanged.
- R6: A DMA access to an owned line sends `fwd_kind`=1 (invalidate) to the owner and clears the ownership. When `inv_data_valid` arrives, memory is written with all byte enables set. For a DMA write the data written is the owner's data with byte i replaced by DMA byte i wherever `dma_req_be[i]`=1. For a DMA read it is the owner's data unchanged, and that same data is returned on `dma_rsp_data`.
- R7: A DMA access to an unowned line goes straight to memory. A read returns `mem_rsp_data`. A write passes `dma_req_be` through as the memory byte enables. `dma_rsp_valid` pulses one cycle after `mem_rsp_valid` (data 0 for writes).
- R8: While a memory exchange or an invalidation is outstanding, `req_ready` and `dma_req_ready` are 0 for as long as the response takes, and other responses are ignored.
- R9: When a core request and a DMA request are both present, the core request is taken. `dma_req_ready` is 1 only when the directory is idle and `req_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Core request accepted this cycle |
| req_kind | input | 1 | 0 exclusive request, 1 writeback |
| req_core | input | CORE_W | Requesting core |
| req_line | input | IDX_W | Line index |
| req_data | input | DATA_W | Writeback data |
| fwd_valid | output | 1 | Forward/invalidate pulse |
| fwd_kind | output | 1 | 0 forwarded exclusive, 1 invalidate |
| fwd_core | output | CORE_W | Current owner addressed |
| fwd_req_core | output | CORE_W | Core that should receive the data |
| fwd_line | output | IDX_W | Line index |
| rsp_valid | output | 1 | Response pulse to a core |
| rsp_kind | output | 2 | 0 data, 1 ack, 2 refusal |
| rsp_core | output | CORE_W | Destination core |
| rsp_line | output | IDX_W | Line index |
| rsp_data | output | DATA_W | Line data for data responses |
| mem_req_valid | output | 1 | Memory command pulse |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_line | output | IDX_W | Line index |
| mem_req_data | output | DATA_W | Write data |
| mem_req_be | output | DATA_W/8 | Write byte enables |
| mem_rsp_valid | input | 1 | Memory read data or write done |
| mem_rsp_data | input | DATA_W | Memory read data |
| inv_data_valid | input | 1 | Invalidated owner returned its copy |
| inv_data | input | DATA_W | Owner's copy |
| dma_req_valid | input | 1 | DMA access present |
| dma_req_ready | output | 1 | DMA access accepted this cycle |
| dma_req_write | input | 1 | 1 write, 0 read |
| dma_req_line | input | IDX_W | Line index |
| dma_req_data | input | DATA_W | DMA write data |
| dma_req_be | input | DATA_W/8 | DMA write byte enables |
| dma_rsp_valid | output | 1 | DMA access complete |
| dma_rsp_data | output | DATA_W | DMA read data |

## Verification
A corrupted ownership record shows up at the next request to that line, one cycle after acceptance. An exclusive request then hits memory instead of a forward, or the forward goes to the wrong core, or a valid writeback is refused or an invalid one accepted. A wrong transient state shows as a ready level that differs from the expected one within the same cycle, or as a response pulse that is missing or has the wrong kind one cycle after the memory or owner reply. Data path faults in the merge appear on the next memory write command and, for DMA reads, on the DMA return one cycle after the memory acknowledgement.

// File: rtl/mi_dir_pkg.sv
package mi_dir_pkg;

    typedef enum logic {
        REQ_GETX = 1'b0,
        REQ_WB   = 1'b1
    } req_kind_e;

    typedef enum logic [1:0] {
        RSP_DATA = 2'd0,
        RSP_ACK  = 2'd1,
        RSP_NACK = 2'd2
    } rsp_kind_e;

    typedef enum logic {
        FWD_GETX = 1'b0,
        FWD_INV  = 1'b1
    } fwd_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_CWR   = 3'd2,
        ST_INV   = 3'd3,
        ST_DWR   = 3'd4,
        ST_DRD   = 3'd5
    } dir_state_e;

endpackage

// File: rtl/mi_owner_table.sv
module mi_owner_table #(
    parameter int NUM_LINES = 8,
    parameter int CORE_W    = 2,
    parameter int IDX_W     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_vld,
    output logic [CORE_W-1:0] rd_id,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_vld,
    input  logic [CORE_W-1:0] wr_id
);

    logic [NUM_LINES-1:0] vld_q;
    logic [CORE_W-1:0]    id_q [NUM_LINES];

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q[i] <= 1'b0;
                id_q[i]  <= '0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                vld_q[i] <= wr_vld;
                id_q[i]  <= wr_id;
            end
        end
    end

    assign rd_vld = vld_q[rd_idx];
    assign rd_id  = id_q[rd_idx];

endmodule

// File: rtl/mi_byte_merge.sv
module mi_byte_merge #(
    parameter int DATA_W = 32,
    localparam int BYTES = DATA_W / 8
) (
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] over,
    input  logic [BYTES-1:0]  be,
    output logic [DATA_W-1:0] merged
);

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign merged[b*8 +: 8] = be[b] ? over[b*8 +: 8] : base[b*8 +: 8];
    end

endmodule

// File: rtl/mi_dir_ctrl.sv
module mi_dir_ctrl
    import mi_dir_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int NUM_LINES = 8,
    parameter int DATA_W    = 32,
    localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int BYTES    = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_kind,
    input  logic [CORE_W-1:0] req_core,
    input  logic [IDX_W-1:0]  req_line,
    input  logic [DATA_W-1:0] req_data,
    output logic              fwd_valid,
    output logic              fwd_kind,
    output logic [CORE_W-1:0] fwd_core,
    output logic [CORE_W-1:0] fwd_req_core,
    output logic [IDX_W-1:0]  fwd_line,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [CORE_W-1:0] rsp_core,
    output logic [IDX_W-1:0]  rsp_line,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [IDX_W-1:0]  mem_req_line,
    output logic [DATA_W-1:0] mem_req_data,
    output logic [BYTES-1:0]  mem_req_be,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    input  logic              inv_data_valid,
    input  logic [DATA_W-1:0] inv_data,
    input  logic              dma_req_valid,
    output logic              dma_req_ready,
    input  logic              dma_req_write,
    input  logic [IDX_W-1:0]  dma_req_line,
    input  logic [DATA_W-1:0] dma_req_data,
    input  logic [BYTES-1:0]  dma_req_be,
    output logic              dma_rsp_valid,
    output logic [DATA_W-1:0] dma_rsp_data
);

    dir_state_e        state_q;
    logic [CORE_W-1:0] p_core_q;
    logic [IDX_W-1:0]  p_line_q;
    logic              p_dwr_q;
    logic [DATA_W-1:0] p_ddata_q;
    logic [BYTES-1:0]  p_be_q;
    logic [DATA_W-1:0] p_hold_q;

    logic              core_acc, dma_acc, wb_hit;
    logic [IDX_W-1:0]  rd_idx;
    logic              own_v;
    logic [CORE_W-1:0] own_id;
    logic              tw_en, tw_vld;
    logic [IDX_W-1:0]  tw_idx;
    logic [CORE_W-1:0] tw_id;
    logic [DATA_W-1:0] merged;

    assign req_ready     = (state_q == ST_IDLE);
    assign dma_req_ready = (state_q == ST_IDLE) && !req_valid;
    assign core_acc      = req_valid && req_ready;
    assign dma_acc       = dma_req_valid && dma_req_ready;
    assign rd_idx        = req_valid ? req_line : dma_req_line;
    assign wb_hit        = own_v && (own_id == req_core);

    mi_owner_table #(
        .NUM_LINES (NUM_LINES),
        .CORE_W    (CORE_W),
        .IDX_W     (IDX_W)
    ) u_table (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (rd_idx),
        .rd_vld (own_v),
        .rd_id  (own_id),
        .wr_en  (tw_en),
        .wr_idx (tw_idx),
        .wr_vld (tw_vld),
        .wr_id  (tw_id)
    );

    mi_byte_merge #(
        .DATA_W (DATA_W)
    ) u_merge (
        .base   (inv_data),
        .over   (p_ddata_q),
        .be     (p_be_q),
        .merged (merged)
    );

    // Ownership updates: forward transfers at once, owner writeback and
    // DMA invalidation clear, a completed fetch installs the requester.
    always_comb begin
        tw_en  = 1'b0;
        tw_idx = rd_idx;
        tw_vld = 1'b0;
        tw_id  = req_core;
        if (core_acc) begin
            if (req_kind_e'(req_kind) == REQ_GETX) begin
                tw_en  = own_v;
                tw_vld = 1'b1;
            end else begin
                tw_en  = wb_hit;
            end
        end else if (dma_acc) begin
            tw_en = own_v;
        end else if (state_q == ST_FETCH && mem_rsp_valid) begin
            tw_en  = 1'b1;
            tw_idx = p_line_q;
            tw_vld = 1'b1;
            tw_id  = p_core_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_IDLE;
            p_core_q      <= '0;
            p_line_q      <= '0;
            p_dwr_q       <= 1'b0;
            p_ddata_q     <= '0;
            p_be_q        <= '0;
            p_hold_q      <= '0;
            fwd_valid     <= 1'b0;
            fwd_kind      <= 1'b0;
            fwd_core      <= '0;
            fwd_req_core  <= '0;
            fwd_line      <= '0;
            rsp_valid     <= 1'b0;
            rsp_kind      <= 2'd0;
            rsp_core      <= '0;
            rsp_line      <= '0;
            rsp_data      <= '0;
            mem_req_valid <= 1'b0;
            mem_req_write <= 1'b0;
            mem_req_line  <= '0;
            mem_req_data  <= '0;
            mem_req_be    <= '0;
            dma_rsp_valid <= 1'b0;
            dma_rsp_data  <= '0;
        end else begin
            fwd_valid     <= 1'b0;
            rsp_valid     <= 1'b0;
            mem_req_valid <= 1'b0;
            dma_rsp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (core_acc) begin
                        p_core_q <= req_core;
                        p_line_q <= req_line;
                        if (req_kind_e'(req_kind) == REQ_GETX) begin
                            if (own_v) begin
                                fwd_valid    <= 1'b1;
                                fwd_kind     <= FWD_GETX;
                                fwd_core     <= own_id;
                                fwd_req_core <= req_core;
                                fwd_line     <= req_line;
                            end else begin
                                mem_req_valid <= 1'b1;
                                mem_req_write <= 1'b0;
                                mem_req_line  <= req_line;
                                mem_req_data  <= '0;
                                mem_req_be    <= '0;
                                state_q       <= ST_FETCH;
                            end
                        end else if (wb_hit) begin
                            mem_req_valid <= 1'b1;
                            mem_req_write <= 1'b1;
                            mem_req_line  <= req_line;
                            mem_req_data  <= req_data;
                            mem_req_be    <= '1;
                            state_q       <= ST_CWR;
                        end else begin
                            rsp_valid <= 1'b1;
                            rsp_kind  <= RSP_NACK;
                            rsp_core  <= req_core;
                            rsp_line  <= req_line;
                            rsp_data  <= '0;
                        end
                    end else if (dma_acc) begin
                        p_line_q  <= dma_req_line;
                        p_dwr_q   <= dma_req_write;
                        p_ddata_q <= dma_req_data;
                        p_be_q    <= dma_req_be;
                        if (own_v) begin
                            fwd_valid    <= 1'b1;
                            fwd_kind     <= FWD_INV;
                            fwd_core     <= own_id;
                            fwd_req_core <= '0;
                            fwd_line     <= dma_req_line;
                            state_q      <= ST_INV;
                        end else begin
                            mem_req_valid <= 1'b1;
                            mem_req_write <= dma_req_write;
                            mem_req_line  <= dma_req_line;
                            mem_req_data  <= dma_req_write ? dma_req_data : '0;
                            mem_req_be    <= dma_req_write ? dma_req_be : '0;
                            state_q       <= dma_req_write ? ST_DWR : ST_DRD;
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_rsp_valid) begin
                        rsp_valid <= 1'b1;
                        rsp_kind  <= RSP_DATA;
                        rsp_core  <= p_core_q;
                        rsp_line  <= p_line_q;
                        rsp_data  <= mem_rsp_data;
                        state_q   <= ST_IDLE;
                    end
                end
                ST_CWR: begin
                    if (mem_rsp_valid) begin
                        rsp_valid <= 1'b1;
                        rsp_kind  <= RSP_ACK;
                        rsp_core  <= p_core_q;
                        rsp_line  <= p_line_q;
                        rsp_data  <= '0;
                        state_q   <= ST_IDLE;
                    end
                end
                ST_INV: begin
                    if (inv_data_valid) begin
                        p_hold_q      <= inv_data;
                        mem_req_valid <= 1'b1;
                        mem_req_write <= 1'b1;
                        mem_req_line  <= p_line_q;
                        mem_req_data  <= p_dwr_q ? merged : inv_data;
                        mem_req_be    <= '1;
                        state_q       <= ST_DWR;
                    end
                end
                ST_DWR: begin
                    if (mem_rsp_valid) begin
                        dma_rsp_valid <= 1'b1;
                        dma_rsp_data  <= p_dwr_q ? '0 : p_hold_q;
                        state_q       <= ST_IDLE;
                    end
                end
                ST_DRD: begin
                    if (mem_rsp_valid) begin
                        dma_rsp_valid <= 1'b1;
                        dma_rsp_data  <= mem_rsp_data;
                        state_q       <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R8
    mem_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready && !dma_req_ready);

    // R5
    nack_nomem_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind == RSP_NACK) |-> !mem_req_valid);

    // R2
    data_after_mem_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind == RSP_DATA) |-> $past(mem_rsp_valid));

    // R7
    dma_after_mem_chk: assert property (@(posedge clk) disable iff (rst)
        dma_rsp_valid |-> $past(mem_rsp_valid));

    // R3
    fwd_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> $past(req_ready));

endmodule

// File: tb/sim_mi_dir_ctrl.sv
`timescale 1ns/1ps
module sim_mi_dir_ctrl;

    localparam int NC = 4;
    localparam int NL = 8;
    localparam int DW = 32;
    localparam int CW = 2;
    localparam int IW = 3;
    localparam int BY = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          req_valid = 0, req_kind = 0;
    logic [CW-1:0] req_core = 0;
    logic [IW-1:0] req_line = 0;
    logic [DW-1:0] req_data = 0;
    logic          req_ready;
    logic          fwd_valid, fwd_kind;
    logic [CW-1:0] fwd_core, fwd_req_core;
    logic [IW-1:0] fwd_line;
    logic          rsp_valid;
    logic [1:0]    rsp_kind;
    logic [CW-1:0] rsp_core;
    logic [IW-1:0] rsp_line;
    logic [DW-1:0] rsp_data;
    logic          mem_req_valid, mem_req_write;
    logic [IW-1:0] mem_req_line;
    logic [DW-1:0] mem_req_data;
    logic [BY-1:0] mem_req_be;
    logic          mem_rsp_valid = 0;
    logic [DW-1:0] mem_rsp_data = 0;
    logic          inv_data_valid = 0;
    logic [DW-1:0] inv_data = 0;
    logic          dma_req_valid = 0, dma_req_write = 0;
    logic [IW-1:0] dma_req_line = 0;
    logic [DW-1:0] dma_req_data = 0;
    logic [BY-1:0] dma_req_be = 0;
    logic          dma_req_ready, dma_rsp_valid;
    logic [DW-1:0] dma_rsp_data;

    mi_dir_ctrl #(.NUM_CORES(NC), .NUM_LINES(NL), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_core(req_core), .req_line(req_line), .req_data(req_data),
        .fwd_valid(fwd_valid), .fwd_kind(fwd_kind), .fwd_core(fwd_core),
        .fwd_req_core(fwd_req_core), .fwd_line(fwd_line),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_core(rsp_core),
        .rsp_line(rsp_line), .rsp_data(rsp_data),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_line(mem_req_line), .mem_req_data(mem_req_data), .mem_req_be(mem_req_be),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .inv_data_valid(inv_data_valid), .inv_data(inv_data),
        .dma_req_valid(dma_req_valid), .dma_req_ready(dma_req_ready),
        .dma_req_write(dma_req_write), .dma_req_line(dma_req_line),
        .dma_req_data(dma_req_data), .dma_req_be(dma_req_be),
        .dma_rsp_valid(dma_rsp_valid), .dma_rsp_data(dma_rsp_data)
    );

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;
    bit done    = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    function automatic logic [DW-1:0] mrg(input logic [DW-1:0] b, input logic [DW-1:0] o, input logic [BY-1:0] be);
        logic [DW-1:0] r;
        r = b;
        for (int i = 0; i < BY; i++) if (be[i]) r[i*8 +: 8] = o[i*8 +: 8];
        return r;
    endfunction

    // ---------------- reference model ----------------
    int ms = 0;
    bit ov [NL];
    int oid [NL];
    int p_core, p_line;
    bit p_dw;
    logic [DW-1:0] p_dd, p_hold;
    logic [BY-1:0] p_be;
    bit core_acc_f, dma_acc_f;
    bit e_fwd_v, e_fwd_k; int e_fwd_c, e_fwd_r, e_fwd_l;
    bit e_rsp_v; int e_rsp_k, e_rsp_c, e_rsp_l; logic [DW-1:0] e_rsp_d;
    bit e_mem_v, e_mem_w; int e_mem_l; logic [DW-1:0] e_mem_d; logic [BY-1:0] e_mem_be;
    bit e_dma_v; logic [DW-1:0] e_dma_d;
    string mtag = "R7", dtag = "R7";

    task automatic mem_cmd(input bit w, input int l, input logic [DW-1:0] d, input logic [BY-1:0] be, input string t);
        e_mem_v = 1; e_mem_w = w; e_mem_l = l; e_mem_d = w ? d : '0; e_mem_be = w ? be : '0; mtag = t;
    endtask

    always @(posedge clk) begin
        core_acc_f = 0; dma_acc_f = 0;
        e_fwd_v = 0; e_rsp_v = 0; e_mem_v = 0; e_dma_v = 0;
        if (rst) begin
            ms = 0;
            for (int i = 0; i < NL; i++) begin ov[i] = 0; oid[i] = 0; end
        end else begin
            case (ms)
                0: if (req_valid) begin
                       int l, c;
                       core_acc_f = 1; l = req_line; c = req_core;
                       p_core = c; p_line = l;
                       if (req_kind == 0) begin
                           if (ov[l]) begin
                               e_fwd_v = 1; e_fwd_k = 0; e_fwd_c = oid[l]; e_fwd_r = c; e_fwd_l = l;
                               oid[l] = c;
                           end else begin
                               mem_cmd(0, l, 0, 0, "R2"); ms = 1;
                           end
                       end else if (ov[l] && oid[l] == c) begin
                           mem_cmd(1, l, req_data, '1, "R4"); ov[l] = 0; ms = 2;
                       end else begin
                           e_rsp_v = 1; e_rsp_k = 2; e_rsp_c = c; e_rsp_l = l; e_rsp_d = 0;
                       end
                   end else if (dma_req_valid) begin
                       int l;
                       dma_acc_f = 1; l = dma_req_line;
                       p_line = l; p_dw = dma_req_write; p_dd = dma_req_data; p_be = dma_req_be;
                       if (ov[l]) begin
                           e_fwd_v = 1; e_fwd_k = 1; e_fwd_c = oid[l]; e_fwd_r = 0; e_fwd_l = l;
                           ov[l] = 0; ms = 3; dtag = "R6";
                       end else begin
                           mem_cmd(dma_req_write, l, dma_req_data, dma_req_be, "R7");
                           ms = dma_req_write ? 4 : 5; dtag = "R7";
                       end
                   end
                1: if (mem_rsp_valid) begin
                       e_rsp_v = 1; e_rsp_k = 0; e_rsp_c = p_core; e_rsp_l = p_line; e_rsp_d = mem_rsp_data;
                       ov[p_line] = 1; oid[p_line] = p_core; ms = 0;
                   end
                2: if (mem_rsp_valid) begin
                       e_rsp_v = 1; e_rsp_k = 1; e_rsp_c = p_core; e_rsp_l = p_line; e_rsp_d = 0; ms = 0;
                   end
                3: if (inv_data_valid) begin
                       p_hold = inv_data;
                       mem_cmd(1, p_line, p_dw ? mrg(inv_data, p_dd, p_be) : inv_data, '1, "R6");
                       ms = 4;
                   end
                4: if (mem_rsp_valid) begin
                       e_dma_v = 1; e_dma_d = p_dw ? '0 : p_hold; ms = 0;
                   end
                5: if (mem_rsp_valid) begin
                       e_dma_v = 1; e_dma_d = mem_rsp_data; ms = 0;
                   end
                default: ms = 0;
            endcase
        end
    end

    // ---------------- external responders ----------------
    logic [DW-1:0] mem_arr [NL];
    int mem_lat = 2, inv_lat = 3;
    int mem_cnt = -1, inv_cnt = -1;
    bit mq_w; int mq_l; logic [DW-1:0] mq_d; logic [BY-1:0] mq_be;
    int iq_l, iq_o, inv_seq = 0;

    initial for (int i = 0; i < NL; i++) mem_arr[i] = 32'h5A5A0000 ^ (i * 32'h01010101);

    always @(negedge clk) begin
        if (!rst) begin
            logic [63:0] a, e;
            string t;
            chk(req_ready == (ms == 0), "R8", {63'd0, req_ready}, {63'd0, ms == 0});
            chk(dma_req_ready == ((ms == 0) && !req_valid), "R9", {63'd0, dma_req_ready},
                {63'd0, (ms == 0) && !req_valid});
            a = fwd_valid ? {32'd1, 15'd0, fwd_kind, 6'd0, fwd_core, 6'd0,
                             (fwd_kind ? 2'd0 : fwd_req_core), 5'd0, fwd_line} : 64'd0;
            e = e_fwd_v ? {32'd1, 15'd0, e_fwd_k, 6'd0, CW'(e_fwd_c), 6'd0,
                           (e_fwd_k ? 2'd0 : CW'(e_fwd_r)), 5'd0, IW'(e_fwd_l)} : 64'd0;
            t = (e_fwd_v && e_fwd_k) || (fwd_valid && fwd_kind) ? "R6" : "R3";
            chk(a == e, t, a, e);
            a = rsp_valid ? {4'd1, 2'd0, rsp_kind, 6'd0, rsp_core, 5'd0, rsp_line, 8'd0,
                             (rsp_kind == 0 ? rsp_data : 32'd0)} : 64'd0;
            e = e_rsp_v ? {4'd1, 2'd0, 2'(e_rsp_k), 6'd0, CW'(e_rsp_c), 5'd0, IW'(e_rsp_l), 8'd0,
                           (e_rsp_k == 0 ? e_rsp_d : 32'd0)} : 64'd0;
            t = !e_rsp_v ? "R5" : (e_rsp_k == 0 ? "R2" : (e_rsp_k == 1 ? "R4" : "R5"));
            chk(a == e, t, a, e);
            a = mem_req_valid ? {4'd1, 3'd0, mem_req_write, 5'd0, mem_req_line, 4'd0, mem_req_be,
                                 8'd0, (mem_req_write ? mem_req_data : 32'd0)} : 64'd0;
            e = e_mem_v ? {4'd1, 3'd0, e_mem_w, 5'd0, IW'(e_mem_l), 4'd0, e_mem_be, 8'd0, e_mem_d} : 64'd0;
            chk(a == e, e_mem_v ? mtag : "R8", a, e);
            a = dma_rsp_valid ? {32'd1, dma_rsp_data} : 64'd0;
            e = e_dma_v ? {32'd1, e_dma_d} : 64'd0;
            chk(a == e, dtag, a, e);
        end
        #1;
        mem_rsp_valid = 0;
        inv_data_valid = 0;
        if (mem_req_valid) begin
            mq_w = mem_req_write; mq_l = mem_req_line; mq_d = mem_req_data; mq_be = mem_req_be;
            mem_cnt = mem_lat;
        end
        if (mem_cnt == 0) begin
            mem_rsp_valid = 1;
            mem_rsp_data  = mq_w ? '0 : mem_arr[mq_l];
            if (mq_w) mem_arr[mq_l] = mrg(mem_arr[mq_l], mq_d, mq_be);
            mem_cnt = -1;
        end else if (mem_cnt > 0) mem_cnt--;
        if (fwd_valid && fwd_kind) begin
            iq_l = fwd_line; iq_o = fwd_core; inv_cnt = inv_lat;
        end
        if (inv_cnt == 0) begin
            inv_data_valid = 1;
            inv_data = {8'hA5, 8'(inv_seq), 8'(iq_l), 8'(iq_o)};
            inv_seq++;
            inv_cnt = -1;
        end else if (inv_cnt > 0) inv_cnt--;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL R8 watchdog: actual %0d cycles expected below 150000", cyc);
            summary();
        end
    end

    // ---------------- stimulus ----------------
    task automatic core_op(input bit k, input int c, input int l, input logic [DW-1:0] d);
        @(negedge clk); #1;
        req_valid = 1; req_kind = k; req_core = CW'(c); req_line = IW'(l); req_data = d;
        forever begin
            @(negedge clk); #1;
            if (core_acc_f) break;
        end
        req_valid = 0;
    endtask

    task automatic dma_op(input bit w, input int l, input logic [DW-1:0] d, input logic [BY-1:0] be);
        @(negedge clk); #1;
        dma_req_valid = 1; dma_req_write = w; dma_req_line = IW'(l); dma_req_data = d; dma_req_be = be;
        forever begin
            @(negedge clk); #1;
            if (dma_acc_f) break;
        end
        dma_req_valid = 0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!(ms == 0 && mem_cnt < 0 && inv_cnt < 0 && !req_valid && !dma_req_valid));
        repeat (2) @(negedge clk);
    endtask

    logic [15:0] lf = 16'hACE1;

    initial begin
        repeat (4) @(negedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1: reset state at the ports
        chk(req_ready && !fwd_valid && !rsp_valid && !mem_req_valid && !dma_rsp_valid, "R1",
            {59'd0, req_ready, fwd_valid, rsp_valid, mem_req_valid, dma_rsp_valid}, 64'h10);
        // R1, R2: first request to an unowned line goes to memory
        core_op(0, 0, 1, 0); wait_idle();
        // R3: forward to owner 0, core 2 takes over
        core_op(0, 2, 1, 0); wait_idle();
        // R5: stale writeback from core 0
        core_op(1, 0, 1, 32'hDEAD0001); wait_idle();
        // R4: owner writeback
        core_op(1, 2, 1, 32'h11223344); wait_idle();
        // R4: ownership cleared, fetch from memory again
        core_op(0, 1, 1, 0); wait_idle();
        // R6: DMA write to owned line, byte merge
        dma_op(1, 1, 32'hCAFEBABE, 4'b0101); wait_idle();
        // R7: DMA read of unowned line
        dma_op(0, 3, 0, 0); wait_idle();
        // R6: DMA read of owned line returns owner data
        core_op(0, 3, 5, 0); wait_idle();
        dma_op(0, 5, 0, 0); wait_idle();
        // R7: DMA write unowned with byte enables, then read back
        dma_op(1, 6, 32'h99887766, 4'b0011); wait_idle();
        dma_op(0, 6, 0, 0); wait_idle();
        // R9: simultaneous core and DMA requests
        fork
            core_op(0, 1, 2, 0);
            dma_op(0, 4, 0, 0);
        join
        wait_idle();
        // R8: long memory latency with other requests waiting
        mem_lat = 60; inv_lat = 45;
        fork
            core_op(0, 0, 7, 0);
            begin repeat (3) @(negedge clk); core_op(0, 1, 2, 0); end
            begin repeat (5) @(negedge clk); dma_op(0, 7, 0, 0); end
        join
        wait_idle();
        mem_lat = 2; inv_lat = 3;
        // mixed sequence
        for (int n = 0; n < 300; n++) begin
            int op, c, l;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            op = lf[1:0]; c = lf[3:2]; l = lf[5:4];
            mem_lat = lf[14:12]; inv_lat = lf[11:9];
            case (op)
                0, 1: core_op(0, c, l, 0);
                2: begin
                       if (lf[6] && ov[l]) c = oid[l];
                       core_op(1, c, l, {lf, ~lf});
                   end
                default: dma_op(lf[7], l, {~lf, lf}, lf[11:8]);
            endcase
            if (lf[15]) wait_idle();
        end
        wait_idle();
        done = 1;
        summary();
    end

endmodule